// File: doc/BRIEF.md
# Multiplexed Scan Timing Controller

This block paces the conversions of a multiplexed analog-input front end. It runs on one timebase clock. An asynchronous sample pulse starts a scan. The scan then issues one single-cycle convert strobe for each entry of the scan list and presents the channel number the multiplexer should select.

Converts can come from two sources:
- **Internal pacing:** the first strobe of a scan waits a programmable start delay, and each later strobe waits a programmable gap.
- **External pacing:** the strobes follow the edges of an external convert pulse.

Both asynchronous inputs cross into the timebase domain through their own synchronizer and rising-edge detector. The scan start therefore carries up to one tick of uncertainty relative to the external edge. Sample edges that arrive during a scan are counted as overruns and do not restart the scan. Surplus convert edges after the last channel are dropped until the next scan.

Top module: `scan_pacer`

## Requirements
- R1: A synchronized rising edge of `smp_clk_in` while idle starts a scan. The scan issues exactly N strobes on `cnv_strobe`, where N is `scan_len`, and a `scan_len` of 0 counts as 1. `scan_busy` is high from the start edge until the final strobe.
- R2: In internal mode (`use_ext_cnv`=0), the first strobe appears D timebase ticks after the scan-start edge. A `start_dly` of 0 selects the default D=3. An input change on `smp_clk_in` is seen as a strobe D+3 clock edges after the first edge that samples it.
- R3: A `start_dly` of 1 is raised to the floor of 2 ticks. Values of 2 and above are used as given.
- R4: In internal mode, consecutive strobes of one scan are `cnv_gap` ticks apart. A `cnv_gap` of 0 is treated as 1.
- R5: In external mode (`use_ext_cnv`=1, sampled at scan start), each synchronized rising edge of `ext_cnv_in` during a scan issues one strobe, and no start delay is applied. If the same signal drives both inputs, the first strobe is issued on the same edge that starts the scan, 3 clock edges after the input is first sampled.
- R6: Once N strobes have been issued, further convert edges produce no strobe until a new scan starts.
- R7: `scan_done` pulses for one cycle, in the same cycle as the final strobe. After that pulse `scan_busy` is low.
- R8: A sample edge that arrives while `scan_busy` is high sets the sticky `overrun` flag and does not restart or lengthen the scan. `ovr_clr` clears the flag, and a new overrun in the same cycle wins over the clear.
- R9: During each strobe, `chan_idx` holds that strobe's position in the scan, counting 0, 1, … N-1. After reset it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_clk_in | input | 1 | Asynchronous sample pulse; its rising edge starts a scan |
| ext_cnv_in | input | 1 | Asynchronous external convert pulse |
| use_ext_cnv | input | 1 | 1 = external convert pacing; sampled at scan start |
| start_dly | input | DLY_W | Ticks from scan start to first internal strobe (0 = default, 1 raised to 2) |
| cnv_gap | input | GAP_W | Ticks between internal strobes (0 treated as 1) |
| scan_len | input | CH_W | Number of channels in the scan (0 treated as 1) |
| ovr_clr | input | 1 | Clears the overrun flag |
| cnv_strobe | output | 1 | One-cycle convert strobe |
| chan_idx | output | CH_W | Channel position of the current strobe |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle pulse with the final strobe |
| overrun | output | 1 | Sticky flag: sample edge arrived during a scan |

## Verification
The bench measures the exact clock-edge latency from the sample pulse to the first strobe. It does this for the default delay, a delay of 1 that must be raised to 2, and a larger delay. An off-by-one in the counter load or in the synchronizer depth shows up there as a strobe one cycle early or late. Gaps of 0 and 3 are run to catch a design that stalls on, or skips, back-to-back strobes.

In external mode the bench ties both inputs together and expects the strobe on the scan-start edge. It also sends an extra convert edge after the last channel, which a design that does not close the scan would turn into a surplus strobe. A second sample pulse sent mid-scan must raise overrun without adding strobes, so a design that restarts the scan is caught by its strobe count.

// File: rtl/scan_pacer_pkg.sv
package scan_pacer_pkg;
   localparam int unsigned DLY_FLOOR = 2;
   localparam int unsigned GAP_FLOOR = 1;
endpackage

// File: rtl/scan_edge_sync.sv
module scan_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("scan_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise = chain_q[STAGES-1] & ~last_q;

   // A detected edge never lasts more than one cycle (R1, R5)
   p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/scan_tick_counter.sv
module scan_tick_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         run,
   output logic         expire
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (run && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire = run && (cnt_q == W'(1));

   // A loaded count is never zero, so expiry can always be reached (R3, R4)
   p_load_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> load_val != '0);
endmodule

// File: rtl/scan_pacer.sv
module scan_pacer
   import scan_pacer_pkg::*;
#(
   parameter int unsigned DLY_W       = 8,
   parameter int unsigned GAP_W       = 8,
   parameter int unsigned CH_W        = 4,
   parameter int unsigned DEF_DLY     = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_clk_in,
   input  logic             ext_cnv_in,
   input  logic             use_ext_cnv,
   input  logic [DLY_W-1:0] start_dly,
   input  logic [GAP_W-1:0] cnv_gap,
   input  logic [CH_W-1:0]  scan_len,
   input  logic             ovr_clr,
   output logic             cnv_strobe,
   output logic [CH_W-1:0]  chan_idx,
   output logic             scan_busy,
   output logic             scan_done,
   output logic             overrun
);
   localparam int unsigned CNT_W = (DLY_W > GAP_W) ? DLY_W : GAP_W;

   generate
      if (DEF_DLY < DLY_FLOOR) begin : g_bad_def
         $error("scan_pacer: DEF_DLY below the delay floor");
      end
      if (DEF_DLY >= (1 << DLY_W)) begin : g_bad_def_w
         $error("scan_pacer: DEF_DLY does not fit DLY_W");
      end
      if (CH_W < 1) begin : g_bad_ch
         $error("scan_pacer: CH_W must be at least 1");
      end
   endgenerate

   logic smp_rise, cnv_rise;

   scan_edge_sync #(.STAGES(SYNC_STAGES)) u_smp_sync (
      .clk(clk), .rst_n(rst_n), .async_in(smp_clk_in), .rise(smp_rise));

   scan_edge_sync #(.STAGES(SYNC_STAGES)) u_cnv_sync (
      .clk(clk), .rst_n(rst_n), .async_in(ext_cnv_in), .rise(cnv_rise));

   logic             busy_q, ext_q, strobe_q, done_q, ovr_q;
   logic [CH_W-1:0]  issued_q, idx_q;
   logic [CH_W-1:0]  len_eff, k_now;
   logic [CNT_W-1:0] dly_eff, gap_eff, load_val;
   logic             start, ext_now, fire, last, tick_exp, cnt_load;

   always_comb begin
      len_eff = (scan_len == '0) ? CH_W'(1) : scan_len;
      if (start_dly == '0)
         dly_eff = CNT_W'(DEF_DLY);
      else if (start_dly < DLY_W'(DLY_FLOOR))
         dly_eff = CNT_W'(DLY_FLOOR);
      else
         dly_eff = CNT_W'(start_dly);
      gap_eff = (cnv_gap < GAP_W'(GAP_FLOOR)) ? CNT_W'(GAP_FLOOR) : CNT_W'(cnv_gap);
   end

   assign start   = smp_rise & ~busy_q;
   assign ext_now = start ? use_ext_cnv : ext_q;
   assign k_now   = start ? '0 : issued_q;
   assign fire    = ext_now ? (cnv_rise & (start | busy_q)) : (busy_q & tick_exp);
   assign last    = fire && (k_now == len_eff - 1'b1);

   assign cnt_load = (start & ~use_ext_cnv) | (fire & ~last & ~ext_now);
   assign load_val = start ? dly_eff : gap_eff;

   scan_tick_counter #(.W(CNT_W)) u_pace (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(load_val),
      .run(busy_q & ~ext_q), .expire(tick_exp));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         ext_q    <= 1'b0;
         strobe_q <= 1'b0;
         done_q   <= 1'b0;
         ovr_q    <= 1'b0;
         issued_q <= '0;
         idx_q    <= '0;
      end else begin
         strobe_q <= fire;
         done_q   <= last;
         if (start) begin
            busy_q <= ~last;
            ext_q  <= use_ext_cnv;
         end else if (last) begin
            busy_q <= 1'b0;
         end
         if (fire) begin
            idx_q    <= k_now;
            issued_q <= k_now + 1'b1;
         end else if (start) begin
            issued_q <= '0;
         end
         if (smp_rise && busy_q)
            ovr_q <= 1'b1;
         else if (ovr_clr)
            ovr_q <= 1'b0;
      end
   end

   assign cnv_strobe = strobe_q;
   assign chan_idx   = idx_q;
   assign scan_busy  = busy_q;
   assign scan_done  = done_q;
   assign overrun    = ovr_q;

   // End-of-scan pulse always coincides with a strobe (R7)
   p_done_with_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> cnv_strobe);
   // After the end-of-scan pulse the block is idle unless a new scan began (R7)
   p_idle_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> !scan_busy || $past(smp_rise));
   // A strobe that is not the last leaves the scan running (R1)
   p_busy_mid_scan_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_strobe && !scan_done |-> scan_busy);
   // Strobe channel position stays inside the scan list (R9)
   p_idx_in_list_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_strobe |-> chan_idx < len_eff);
   // Internal pacing never strobes on the tick right after the start (R3)
   p_min_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start && !use_ext_cnv |=> !cnv_strobe);
   // Overrun stays set until cleared (R8)
   p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && !ovr_clr |=> overrun);
endmodule

// File: tb/scan_pacer_bench.sv
module scan_pacer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MAXC = 80;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       smp_clk_in = 0, ext_cnv_in = 0, use_ext_cnv = 0, ovr_clr = 0;
   logic [7:0] start_dly = 0, cnv_gap = 1;
   logic [3:0] scan_len = 1;
   logic       cnv_strobe, scan_busy, scan_done, overrun;
   logic [3:0] chan_idx;

   int checks = 0, errors = 0;
   logic       s_str [MAXC];
   logic       s_done[MAXC];
   logic       s_busy[MAXC];
   int         s_idx [MAXC];

   always #(CLK_PERIOD/2) clk = ~clk;

   scan_pacer u_scan_pacer (
      .clk(clk), .rst_n(rst_n), .smp_clk_in(smp_clk_in), .ext_cnv_in(ext_cnv_in),
      .use_ext_cnv(use_ext_cnv), .start_dly(start_dly), .cnv_gap(cnv_gap),
      .scan_len(scan_len), .ovr_clr(ovr_clr), .cnv_strobe(cnv_strobe),
      .chan_idx(chan_idx), .scan_busy(scan_busy), .scan_done(scan_done),
      .overrun(overrun));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Pulses the sample input at cycle 0 (3 cycles wide), drives ext_cnv_in
   // from mask bit c after each sample point, and records outputs per cycle.
   task automatic capture(input int ncyc, input logic [MAXC-1:0] cmask, input bit smp_again_at);
      @(negedge clk);
      smp_clk_in = 1;
      ext_cnv_in = cmask[0];
      for (int c = 1; c < ncyc; c++) begin
         @(posedge clk);
         @(negedge clk);
         s_str[c]  = cnv_strobe;
         s_done[c] = scan_done;
         s_busy[c] = scan_busy;
         s_idx[c]  = chan_idx;
         smp_clk_in = (c < 3) || (smp_again_at && c >= 6 && c < 9);
         ext_cnv_in = cmask[c];
      end
      smp_clk_in = 0;
      ext_cnv_in = 0;
      repeat (4) @(negedge clk);
   endtask

   function automatic int nth_strobe(input int n, input int ncyc);
      int k = 0;
      for (int c = 1; c < ncyc; c++)
         if (s_str[c]) begin
            if (k == n) return c;
            k++;
         end
      return -1;
   endfunction

   function automatic int strobe_count(input int ncyc);
      int k = 0;
      for (int c = 1; c < ncyc; c++) if (s_str[c]) k++;
      return k;
   endfunction

   task automatic t_reset;
      chk("R9 reset chan_idx", chan_idx, 0);
      chk("R1 reset busy", scan_busy, 0);
      chk("R1 reset strobe", cnv_strobe, 0);
      chk("R7 reset done", scan_done, 0);
      chk("R8 reset overrun", overrun, 0);
   endtask

   task automatic t_internal_walk;
      use_ext_cnv = 0; start_dly = 5; cnv_gap = 3; scan_len = 4;
      capture(30, '0, 0);
      chk("R2 first strobe at D+3", nth_strobe(0, 30), 8);
      chk("R4 gap 3 second", nth_strobe(1, 30), 11);
      chk("R4 gap 3 fourth", nth_strobe(3, 30), 17);
      chk("R1 strobe count", strobe_count(30), 4);
      chk("R1 busy during scan", s_busy[10], 1);
      for (int n = 0; n < 4; n++)
         chk("R9 chan per strobe", s_idx[nth_strobe(n, 30)], n);
      chk("R7 done with final", s_done[17], 1);
      chk("R7 done single cycle", s_done[18], 0);
      chk("R7 idle after final", s_busy[18], 0);
      chk("R7 no early done", s_done[14], 0);
   endtask

   task automatic t_default_and_floor;
      use_ext_cnv = 0; cnv_gap = 0; scan_len = 3;
      start_dly = 0;
      capture(20, '0, 0);
      chk("R2 default delay 3", nth_strobe(0, 20), 6);
      chk("R4 gap 0 acts as 1", nth_strobe(1, 20), 7);
      chk("R4 gap 0 third", nth_strobe(2, 20), 8);
      start_dly = 1;
      capture(20, '0, 0);
      chk("R3 delay 1 raised to 2", nth_strobe(0, 20), 5);
      start_dly = 2;
      capture(20, '0, 0);
      chk("R3 delay 2 used", nth_strobe(0, 20), 5);
      scan_len = 0;
      capture(20, '0, 0);
      chk("R1 len 0 counts 1", strobe_count(20), 1);
   endtask

   task automatic t_external;
      logic [MAXC-1:0] m;
      use_ext_cnv = 1; start_dly = 10; cnv_gap = 9; scan_len = 2;
      m = '0;
      m[2:0] = 3'b111; m[10:8] = 3'b111; m[18:16] = 3'b111;
      capture(30, m, 0);
      chk("R5 tied first strobe same edge", nth_strobe(0, 30), 3);
      chk("R5 second ext strobe", nth_strobe(1, 30), 11);
      chk("R6 surplus convert dropped", strobe_count(30), 2);
      chk("R7 ext done on final", s_done[11], 1);
      chk("R9 ext chan second", s_idx[11], 1);
      m = '0;
      m[8:6] = 3'b111;
      scan_len = 1;
      capture(20, m, 0);
      chk("R5 ext strobe no delay", nth_strobe(0, 20), 9);
      chk("R5 ext single strobe", strobe_count(20), 1);
   endtask

   task automatic t_overrun;
      use_ext_cnv = 0; start_dly = 2; cnv_gap = 5; scan_len = 3;
      capture(30, '0, 1);
      chk("R8 no restart strobe count", strobe_count(30), 3);
      chk("R8 final strobe unchanged", nth_strobe(2, 30), 15);
      chk("R8 overrun set", overrun, 1);
      @(negedge clk); ovr_clr = 1;
      @(negedge clk); ovr_clr = 0;
      chk("R8 overrun cleared", overrun, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      repeat (2) @(negedge clk);
      t_internal_walk();
      t_default_and_floor();
      t_external();
      t_overrun();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule